// File: doc/BRIEF.md
# Recursive Sine-Cosine Oscillator

This block produces a pair of sampled sinusoids in fixed point by repeatedly multiplying the previous output pair by a constant 2×2 matrix. It does not use a sine term. Both diagonal entries are the programmed coefficient c = cos(θ). The upper off-diagonal entry is c+1 and the lower one is c−1. The matrix has determinant one, so for |c| < 1 the pair circles an ellipse with a period of 2π/θ samples. A host loads two starting values and the coefficient with a single strobe. Each cycle that the step enable is high then yields one new sample pair. Four multipliers and two adders work in parallel, so throughput is one step per clock.

All values are signed 18-bit Q1.16: the range is [−2, 2) and one LSB is 2^−16. The two offset coefficients are computed once, at load time, and saturated to that range. Each product is rounded to nearest, with halves going upward, and saturated to 18 bits. The two rounded products of a row are then added with saturation, and the result is written back as the new state.

Top module: `sincos_osc`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `s1_out` = 0, `s2_out` = 0 and `out_valid` = 0.
- R2: A clock edge with `load` high sets `s1_out` and `s2_out` to `init_s1` and `init_s2`, and clears `out_valid`. `load` takes priority over `step_en` in the same cycle.
- R3: A step sets the new `s1_out` to sat(rnd(c·s1) + rnd(k_p·s2)), where k_p is the upper off-diagonal coefficient.
- R4: A step sets the new `s2_out` to sat(rnd(k_m·s1) + rnd(c·s2)), where k_m is the lower off-diagonal coefficient.
- R5: At load time, k_p = clamp(c + 65536) and k_m = clamp(c − 65536), where clamp limits a value to [−131072, 131071].
- R6: rnd(p) for a 36-bit product p is clamp(floor((p + 32768) / 65536)). For example, 0.5 × 1 LSB rounds up to 1 LSB, and −0.5 × 1 LSB rounds to 0.
- R7: The sum of the two rounded products in a row is clamped to [−131072, 131071].
- R8: A cycle with `load` and `step_en` both low leaves both outputs unchanged and drives `out_valid` low on the next cycle.
- R9: `step_en` has no effect after reset until the first load: the outputs stay 0 and `out_valid` stays low.
- R10: `out_valid` is high in exactly the cycles that follow an edge at which a step occurred. A step occurs when `step_en` is high, `load` is low and the block has been loaded. Back-to-back enables give one new sample per cycle.
- R11: `cos_in` is captured only on a load. Changing it between loads does not alter later steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Captures initial states and coefficient |
| init_s1 | input | 18 | Initial first state, signed Q1.16 |
| init_s2 | input | 18 | Initial second state, signed Q1.16 |
| cos_in | input | 18 | Coefficient cos(θ), signed Q1.16 |
| step_en | input | 1 | Advance the recurrence one step |
| s1_out | output | 18 | First state, signed Q1.16 |
| s2_out | output | 18 | Second state, signed Q1.16 |
| out_valid | output | 1 | A new sample pair was produced in the previous step |

## Verification
The hardest conditions to reach from the ports are the saturating ones: offset coefficients pinned at a format limit, and a row sum that overflows. A natural sinusoid with |c| < 1 and moderate amplitude never produces either. The stimulus therefore loads the extreme coefficients +131071 and −131072 together with large equal or opposite states, so that the first steps clip. Directed half-LSB products exercise the rounding direction for both signs. Gapped enables show that the state holds between steps, and a load arriving in the middle of a run shows that load takes priority. A run of more than a thousand steps compares every sample with a scoreboard that restates the arithmetic using 64-bit integers.

// File: rtl/sincos_pkg.sv
package sincos_pkg;
  localparam int DATA_W = 18;
  localparam int FRAC_W = 16;
  localparam int PROD_W = 2 * DATA_W;
  localparam int ROWS   = 2;

  typedef logic signed [DATA_W-1:0] sample_t;

  localparam longint SMAX = (longint'(1) << (DATA_W - 1)) - 1;
  localparam longint SMIN = -(longint'(1) << (DATA_W - 1));
  localparam longint HALF = longint'(1) << (FRAC_W - 1);
  localparam longint UNIT = longint'(1) << FRAC_W;

  // clamp a wide signed value to the sample range
  function automatic sample_t clip_wide(input logic signed [PROD_W-1:0] v);
    sample_t r;
    if (v > PROD_W'(SMAX))      r = sample_t'(SMAX);
    else if (v < PROD_W'(SMIN)) r = sample_t'(SMIN);
    else                        r = sample_t'(v[DATA_W-1:0]);
    return r;
  endfunction

  // Q1.16 x Q1.16 product, round half up, clamp
  function automatic sample_t mul_rnd(input sample_t a, input sample_t b);
    logic signed [PROD_W-1:0] ae;
    logic signed [PROD_W-1:0] be;
    logic signed [PROD_W-1:0] p;
    ae = a;
    be = b;
    p  = ae * be;
    p  = (p + PROD_W'(HALF)) >>> FRAC_W;
    return clip_wide(p);
  endfunction

  // saturating add of two samples
  function automatic sample_t add_clip(input sample_t a, input sample_t b);
    logic [DATA_W:0] s;
    sample_t r;
    s = {a[DATA_W-1], a} + {b[DATA_W-1], b};
    if (s[DATA_W] != s[DATA_W-1])
      r = s[DATA_W] ? sample_t'(SMIN) : sample_t'(SMAX);
    else
      r = sample_t'(s[DATA_W-1:0]);
    return r;
  endfunction
endpackage

// File: rtl/sincos_coef.sv
module sincos_coef
  import sincos_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    capture,
  input  sample_t cos_in,
  output sample_t c_q,
  output sample_t cp1_q,
  output sample_t cm1_q
);
  localparam sample_t ONE_Q  = sample_t'(UNIT);
  localparam sample_t MONE_Q = sample_t'(-UNIT);

  sample_t cp1_d;
  sample_t cm1_d;

  always_comb begin
    cp1_d = add_clip(cos_in, ONE_Q);
    cm1_d = add_clip(cos_in, MONE_Q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_q   <= '0;
      cp1_q <= '0;
      cm1_q <= '0;
    end else if (capture) begin
      c_q   <= cos_in;
      cp1_q <= cp1_d;
      cm1_q <= cm1_d;
    end
  end
endmodule

// File: rtl/sincos_row.sv
module sincos_row
  import sincos_pkg::*;
(
  input  sample_t ka,
  input  sample_t kb,
  input  sample_t xa,
  input  sample_t xb,
  output sample_t y
);
  sample_t pa;
  sample_t pb;

  always_comb begin
    pa = mul_rnd(ka, xa);
    pb = mul_rnd(kb, xb);
    y  = add_clip(pa, pb);
  end
endmodule

// File: rtl/sincos_state.sv
module sincos_state
  import sincos_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  logic    step_en,
  input  sample_t init_a,
  input  sample_t init_b,
  input  sample_t next_a,
  input  sample_t next_b,
  output sample_t st_a,
  output sample_t st_b,
  output logic    valid,
  output logic    primed,
  output logic    step_fire
);
  assign step_fire = step_en && !load && primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_a   <= '0;
      st_b   <= '0;
      valid  <= 1'b0;
      primed <= 1'b0;
    end else if (load) begin
      st_a   <= init_a;
      st_b   <= init_b;
      valid  <= 1'b0;
      primed <= 1'b1;
    end else if (step_fire) begin
      st_a   <= next_a;
      st_b   <= next_b;
      valid  <= 1'b1;
    end else begin
      valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/sincos_osc.sv
module sincos_osc
  import sincos_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic signed [DATA_W-1:0] init_s1,
  input  logic signed [DATA_W-1:0] init_s2,
  input  logic signed [DATA_W-1:0] cos_in,
  input  logic                     step_en,
  output logic signed [DATA_W-1:0] s1_out,
  output logic signed [DATA_W-1:0] s2_out,
  output logic                     out_valid
);
  sample_t coef_c;
  sample_t coef_p1;
  sample_t coef_m1;
  sample_t st   [ROWS];
  sample_t nxt  [ROWS];
  sample_t ka   [ROWS];
  sample_t kb   [ROWS];
  logic    primed;
  logic    step_fire;

  sincos_coef u_coef (
    .clk    (clk),
    .rst    (rst),
    .capture(load),
    .cos_in (cos_in),
    .c_q    (coef_c),
    .cp1_q  (coef_p1),
    .cm1_q  (coef_m1)
  );

  // row 0: [c, c+1], row 1: [c-1, c]
  assign ka[0] = coef_c;
  assign kb[0] = coef_p1;
  assign ka[1] = coef_m1;
  assign kb[1] = coef_c;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    sincos_row u_row (
      .ka(ka[r]),
      .kb(kb[r]),
      .xa(st[0]),
      .xb(st[1]),
      .y (nxt[r])
    );
  end

  sincos_state u_state (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step_en  (step_en),
    .init_a   (init_s1),
    .init_b   (init_s2),
    .next_a   (nxt[0]),
    .next_b   (nxt[1]),
    .st_a     (st[0]),
    .st_b     (st[1]),
    .valid    (out_valid),
    .primed   (primed),
    .step_fire(step_fire)
  );

  assign s1_out = st[0];
  assign s2_out = st[1];
endmodule

// File: rtl/sincos_osc_chk.sv
module sincos_osc_chk
  import sincos_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    load,
  input logic    step_en,
  input sample_t init_s1,
  input sample_t init_s2,
  input sample_t s1_out,
  input sample_t s2_out,
  input logic    out_valid,
  input sample_t coef_c,
  input sample_t coef_p1,
  input sample_t coef_m1,
  input logic    step_fire
);
  logic seen_load;
  always_ff @(posedge clk) begin
    if (rst)       seen_load <= 1'b0;
    else if (load) seen_load <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (s1_out == '0 && s2_out == '0 && !out_valid));

  assert_load_takes_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (s1_out == $past(init_s1) && s2_out == $past(init_s2) && !out_valid));

  assert_coef_order_R5: assert property (@(posedge clk) disable iff (rst)
    (coef_p1 >= coef_c) && (coef_m1 <= coef_c));

  assert_coef_low_exact_R5: assert property (@(posedge clk) disable iff (rst)
    (coef_c < 0) |-> (longint'(coef_p1) == longint'(coef_c) + UNIT));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && !step_en) |=> ($stable(s1_out) && $stable(s2_out) && !out_valid));

  assert_no_step_unloaded_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> seen_load);

  assert_valid_follows_step_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(step_en) && !$past(load)));

  assert_fire_marks_valid_R10: assert property (@(posedge clk) disable iff (rst)
    step_fire |=> out_valid);
endmodule

bind sincos_osc sincos_osc_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .load     (load),
  .step_en  (step_en),
  .init_s1  (init_s1),
  .init_s2  (init_s2),
  .s1_out   (s1_out),
  .s2_out   (s2_out),
  .out_valid(out_valid),
  .coef_c   (coef_c),
  .coef_p1  (coef_p1),
  .coef_m1  (coef_m1),
  .step_fire(step_fire)
);

// File: tb/sincos_osc_bench.sv
module sincos_osc_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic step_en = 1'b0;
  logic signed [17:0] init_s1 = '0;
  logic signed [17:0] init_s2 = '0;
  logic signed [17:0] cos_in = '0;
  logic signed [17:0] s1_out;
  logic signed [17:0] s2_out;
  logic out_valid;

  always #5 clk = ~clk;

  sincos_osc u_sincos_osc (
    .clk(clk), .rst(rst), .load(load), .init_s1(init_s1), .init_s2(init_s2),
    .cos_in(cos_in), .step_en(step_en), .s1_out(s1_out), .s2_out(s2_out),
    .out_valid(out_valid)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string tag = "R3/R4";

  longint m_s1, m_s2, m_c, m_kp, m_km;
  longint q1[$];
  longint q2[$];

  function automatic longint lim(input longint v);
    if (v > 131071) return 131071;
    if (v < -131072) return -131072;
    return v;
  endfunction

  function automatic longint qmul(input longint a, input longint b);
    longint p;
    p = a * b + 32768;
    return lim(p >>> 16);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(input longint a, input longint b, input longint c);
    @(negedge clk);
    load = 1'b1; init_s1 = 18'(a); init_s2 = 18'(b); cos_in = 18'(c);
    m_s1 = a; m_s2 = b; m_c = c;
    m_kp = lim(c + 65536); m_km = lim(c - 65536);
    @(negedge clk);
    load = 1'b0;
    check("R2 s1", longint'(s1_out), a);
    check("R2 s2", longint'(s2_out), b);
    check("R2 valid", longint'(out_valid), 0);
  endtask

  // driver: one enabled cycle per step, expected pair pushed to scoreboard
  task automatic run_steps(input int n, input int gap_mod);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gap_mod != 0 && (i % gap_mod) == 1) begin
        step_en = 1'b0;
      end else begin
        longint n1, n2;
        step_en = 1'b1;
        n1 = lim(qmul(m_c, m_s1) + qmul(m_kp, m_s2));
        n2 = lim(qmul(m_km, m_s1) + qmul(m_c, m_s2));
        m_s1 = n1; m_s2 = n2;
        q1.push_back(n1); q2.push_back(n2);
      end
    end
    @(negedge clk);
    step_en = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q1.size() == 0) begin
        check({tag, " R10 unexpected valid"}, 1, 0);
      end else begin
        longint e1, e2;
        e1 = q1.pop_front(); e2 = q2.pop_front();
        check({tag, " s1 R3"}, longint'(s1_out), e1);
        check({tag, " s2 R4"}, longint'(s2_out), e2);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    longint h1, h2;
    repeat (3) @(negedge clk);
    check("R1 s1", longint'(s1_out), 0);
    check("R1 s2", longint'(s2_out), 0);
    check("R1 valid", longint'(out_valid), 0);
    rst = 1'b0;

    // R9: enable without prior load
    step_en = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 valid", longint'(out_valid), 0);
    check("R9 s1", longint'(s1_out), 0);
    step_en = 1'b0;

    // R6: half-LSB rounding both signs
    tag = "R6";
    do_load(1, 0, 32768);
    run_steps(1, 0);
    check("R6 round up s1", longint'(s1_out), 1);
    check("R6 round s2", longint'(s2_out), 0);
    do_load(-1, 0, 32768);
    run_steps(1, 0);
    check("R6 neg half s1", longint'(s1_out), 0);
    check("R6 neg half s2", longint'(s2_out), 1);

    // R5/R7: extreme coefficients and overflowing sums
    tag = "R5 R7 pos";
    do_load(100000, 100000, 131071);
    run_steps(4, 0);
    tag = "R5 R7 neg";
    do_load(120000, -120000, -131072);
    run_steps(4, 0);
    tag = "R7 sum clip";
    do_load(131071, 131071, 65536);
    run_steps(1, 0);
    check("R7 s1 clip", longint'(s1_out), 131071);

    // R8: hold while idle
    tag = "R8";
    do_load(0, 20000, 32768);
    run_steps(5, 0);
    h1 = longint'(s1_out); h2 = longint'(s2_out);
    repeat (3) @(negedge clk);
    check("R8 hold s1", longint'(s1_out), h1);
    check("R8 hold s2", longint'(s2_out), h2);
    check("R8 valid low", longint'(out_valid), 0);

    // R11: coefficient change without load ignored
    tag = "R11";
    @(negedge clk); cos_in = 18'sd1000;
    run_steps(6, 0);

    // R2: load wins over step_en in same cycle
    @(negedge clk);
    step_en = 1'b1; load = 1'b1; init_s1 = 18'sd777; init_s2 = -18'sd555; cos_in = 18'sd40000;
    m_s1 = 777; m_s2 = -555; m_c = 40000; m_kp = lim(40000 + 65536); m_km = lim(40000 - 65536);
    @(negedge clk);
    load = 1'b0; step_en = 1'b0;
    check("R2 priority s1", longint'(s1_out), 777);
    check("R2 priority valid", longint'(out_valid), 0);

    // R10: long back-to-back run, then gapped run
    tag = "R10 long";
    do_load(0, 10000, 62595);
    run_steps(1100, 0);
    tag = "R10 gapped";
    run_steps(300, 5);
    @(negedge clk);
    check("R10 queue drained", longint'(q1.size()), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule